// File: doc/BRIEF.md
# Rate-Trimmed Precision Time Counter

This block keeps a 64-bit nanosecond time of day for a network timing subsystem. One of four reference sources supplies the timebase. Each source arrives as a single-cycle strobe in the block's clock domain, and a 2-bit field picks the source that counts. Every strobe from the chosen source adds a 32-bit fractional rate word to a 32-bit phase accumulator. A carry out of the accumulator is one nominal tick. Each tick advances the time by a programmed period in nanoseconds. Software trims the rate by choosing the rate word, which is ceil(2^32 / (reference frequency / nominal frequency)). The reference must be faster than nominal, so only some strobes produce a tick.

The tick stream also drives two other functions. An integer divider turns it into an output clock. Two interval pulse generators count down a nanosecond period that is programmed as the interval minus one tick. On expiry each one raises a pulse that lasts one output-clock period. Generator 0 is meant for a one-pulse-per-second output. All settings and the time itself are reached over a small word-addressed register bus. The bus byte order is set by a parameter and is big-endian by default.

Top module: `ptp_rate_timer`

## Requirements
- R1: After reset all registers read zero, `tod_ns` is zero, and `out_clk` and both `ivl_pulse` bits are low.
- R2: While running, each strobe of the selected source adds the rate word (word 1) to a 32-bit accumulator that starts at zero. Each carry out adds the tick period (word 2, bits 7:0) to `tod_ns`. After K strobes from a fresh start the time is floor(K*rate/2^32) * period.
- R3: Control word 0 bits 5:4 select which `ref_stb` bit is counted. Strobes on the other bits change nothing.
- R4: Control word 0 bit 0 is the run bit. While it is low, the accumulator, the time, the divider and the pulse generators are held at zero, and writes to the time are ignored.
- R5: A new rate word applies from the next strobe. The accumulator phase and the time are kept.
- R6: Word 4 holds the low 32 bits of the time and word 5 the high 32 bits. Writing word 5 stages the high half, and writing word 4 then loads the full 64-bit time. Reading word 4 returns the low half and captures the high half. Reading word 5 returns that captured high half.
- R7: `out_clk` has a period of N ticks and is high for the last floor(N/2) ticks of each period, so its first rising edge follows tick N-floor(N/2). N is word 3, and a value below 2 acts as 2.
- R8: Generator i takes its period P from word 6+i. It starts at P and drops by the tick period on each tick. When fewer than one tick period remains it expires and reloads P. The interval is therefore P/period + 1 ticks when P is a multiple of the period.
- R9: On expiry, `ivl_pulse[i]` rises after that tick. It stays high through the next N-1 ticks and falls on the Nth, where N is the effective divide value.
- R10: Read data appears on `bus_rdata` one cycle after the read. With `BUS_BIG_ENDIAN`=1, bus bits 7:0 carry register bits 31:24, bus bits 15:8 carry bits 23:16, and so on. With 0, the bytes are not swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every reference strobe is sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_stb | input | 4 | One strobe per reference source |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_word | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data in bus byte order |
| bus_rdata | output | 32 | Read data in bus byte order, one cycle after the read |
| tod_ns | output | 64 | Current time in nanoseconds |
| out_clk | output | 1 | Tick rate divided by the divide value |
| ivl_pulse | output | 2 | Interval pulses; bit 0 is the one-per-second output |

## Verification
A strobe sampled on one edge produces the accumulator carry as a registered tick on that edge. The time, the divider output and the pulse outputs then move on the following edge, so every strobe-driven result is in place two edges after the last strobe. The bench therefore stops the strobes and waits three cycles before it compares anything. It samples on the falling edge and counts rising edges of the outputs over whole runs, so a result a cycle early or late in a window does not matter but a wrong count does. Register reads are sampled one falling edge after the edge that captured them.

// File: rtl/ptp_tmr_pkg.sv
// Package: shared constants and helpers for the rate-trimmed time counter.
// Assumes a 32-bit register bus and a 2-bit reference select.
package ptp_tmr_pkg;
    localparam int SEL_W        = 2;
    localparam int NUM_REF      = 1 << SEL_W;
    localparam int NUM_PULSE    = 2;
    localparam int WORD_W       = 32;
    localparam int IDX_W        = 3;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_SEL_LSB = 4;

    localparam logic [IDX_W-1:0] REG_CTRL   = 3'd0;
    localparam logic [IDX_W-1:0] REG_RATE   = 3'd1;
    localparam logic [IDX_W-1:0] REG_TICK   = 3'd2;
    localparam logic [IDX_W-1:0] REG_DIV    = 3'd3;
    localparam logic [IDX_W-1:0] REG_TOD_LO = 3'd4;
    localparam logic [IDX_W-1:0] REG_TOD_HI = 3'd5;
    localparam logic [IDX_W-1:0] REG_PER_0  = 3'd6;
    localparam logic [IDX_W-1:0] REG_PER_1  = 3'd7;

    // Reverse the four bytes of a bus word.
    function automatic logic [WORD_W-1:0] swap32(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/ptp_rate_accum.sv
// Phase accumulator: adds the rate word on every selected strobe and
// emits a one-cycle tick on each carry out. Assumes run_i low clears phase.
module ptp_rate_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             ref_hit_i,
    input  logic [ACC_W-1:0] rate_i,
    output logic             tick_o
);
    logic [ACC_W-1:0] phase_q;

    // Accumulate the rate word and register the carry as the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= '0;
            tick_o  <= 1'b0;
        end else if (ref_hit_i) begin
            {tick_o, phase_q} <= {1'b0, phase_q} + {1'b0, rate_i};
        end else begin
            tick_o <= 1'b0;
        end
    end

    AST_NO_TICK_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !tick_o); // R4
    AST_TICK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(ref_hit_i)); // R3
endmodule

// File: rtl/ptp_tod_counter.sv
// Time-of-day counter: adds the tick period on each tick, or takes a
// software load. Assumes load wins over a tick in the same cycle.
module ptp_tod_counter #(
    parameter int TOD_W  = 64,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              load_i,
    input  logic [TOD_W-1:0]  load_val_i,
    output logic [TOD_W-1:0]  tod_o
);
    // Advance, load or clear the time.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            tod_o <= '0;
        end else if (load_i) begin
            tod_o <= load_val_i;
        end else if (tick_i) begin
            tod_o <= tod_o + TOD_W'(step_i);
        end
    end

    AST_TOD_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i && !load_i) |=> $stable(tod_o)); // R2
    AST_TOD_ZERO_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (tod_o == '0)); // R4
endmodule

// File: rtl/ptp_out_divider.sv
// Output clock divider: counts ticks modulo div_i and drives the output
// high for the last floor(div_i/2) ticks. Assumes div_i >= 2.
module ptp_out_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             out_o
);
    logic [DIV_W-1:0] pos_q;
    logic [DIV_W-1:0] pos_nxt;
    logic [DIV_W-1:0] high_len;

    // Next position in the divide cycle and the length of the high phase.
    always_comb begin
        high_len = div_i >> 1;
        pos_nxt  = (pos_q == div_i - 1'b1) ? '0 : pos_q + 1'b1;
    end

    // Step the position on each tick and register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            pos_q <= '0;
            out_o <= 1'b0;
        end else if (tick_i) begin
            pos_q <= pos_nxt;
            out_o <= (pos_nxt >= div_i - high_len);
        end
    end

    AST_OUT_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o != $past(out_o)) |-> ($past(tick_i) || !$past(run_i))); // R7
endmodule

// File: rtl/ptp_interval_pulse.sv
// Interval pulse generator: counts a nanosecond period down by the tick
// period, pulses on expiry for width_i ticks and reloads. Arms one cycle
// after run rises; assumes no tick arrives in that first cycle.
module ptp_interval_pulse #(
    parameter int PER_W  = 32,
    parameter int STEP_W = 8,
    parameter int WID_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [WID_W-1:0]  width_i,
    output logic              pulse_o
);
    logic [PER_W-1:0] remain_q;
    logic [WID_W-1:0] hold_q;
    logic             armed_q;

    // Count down, reload on expiry and time the pulse width.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            remain_q <= '0;
            hold_q   <= '0;
            armed_q  <= 1'b0;
            pulse_o  <= 1'b0;
        end else if (!armed_q) begin
            remain_q <= period_i;
            armed_q  <= 1'b1;
        end else if (tick_i) begin
            if (remain_q < PER_W'(step_i)) begin
                remain_q <= period_i;
                pulse_o  <= 1'b1;
                hold_q   <= width_i - WID_W'(1);
            end else begin
                remain_q <= remain_q - PER_W'(step_i);
                if (pulse_o) begin
                    if (hold_q == '0) pulse_o <= 1'b0;
                    else              hold_q  <= hold_q - WID_W'(1);
                end
            end
        end
    end

    AST_PULSE_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(tick_i)); // R8
    AST_PULSE_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_o) && $past(run_i)) |-> $past(tick_i)); // R9
endmodule

// File: rtl/ptp_rate_timer.sv
// Top: register file, reference select and the timing datapath.
// Registers are word-indexed; the bus byte order is set by BUS_BIG_ENDIAN.
// Read data is registered and valid one cycle after the read request.
module ptp_rate_timer
    import ptp_tmr_pkg::*;
#(
    parameter bit BUS_BIG_ENDIAN = 1'b1,
    parameter int RATE_W         = 32,
    parameter int TOD_W          = 64,
    parameter int TICK_W         = 8,
    parameter int DIV_W          = 16,
    parameter int PER_W          = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_REF-1:0]   ref_stb,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [IDX_W-1:0]     bus_word,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [TOD_W-1:0]     tod_ns,
    output logic                 out_clk,
    output logic [NUM_PULSE-1:0] ivl_pulse
);
    localparam int HI_W = TOD_W - WORD_W;

    logic [WORD_W-1:0] wd;
    logic [WORD_W-1:0] rd_q;
    logic              run_q;
    logic [SEL_W-1:0]  sel_q;
    logic [RATE_W-1:0] rate_q;
    logic [TICK_W-1:0] tick_ns_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_eff;
    logic [PER_W-1:0]  per_q [NUM_PULSE];
    logic [HI_W-1:0]   hi_stage_q;
    logic [HI_W-1:0]   hi_shadow_q;
    logic              ref_hit;
    logic              tick;
    logic              tod_load;
    logic              wr_en;
    logic              rd_en;

    // Byte-order adaptation between the bus and the register file.
    generate
        if (BUS_BIG_ENDIAN) begin : g_big
            assign wd        = swap32(bus_wdata);
            assign bus_rdata = swap32(rd_q);
        end else begin : g_little
            assign wd        = bus_wdata;
            assign bus_rdata = rd_q;
        end
    endgenerate

    // Decode of the access, the selected source and the divide floor.
    always_comb begin
        wr_en    = bus_en && bus_we;
        rd_en    = bus_en && !bus_we;
        ref_hit  = ref_stb[sel_q];
        tod_load = wr_en && (bus_word == REG_TOD_LO) && run_q;
        div_eff  = (div_q < DIV_W'(2)) ? DIV_W'(2) : div_q;
    end

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            sel_q      <= '0;
            rate_q     <= '0;
            tick_ns_q  <= '0;
            div_q      <= '0;
            hi_stage_q <= '0;
            for (int i = 0; i < NUM_PULSE; i++) per_q[i] <= '0;
        end else if (wr_en) begin
            case (bus_word)
                REG_CTRL: begin
                    run_q <= wd[CTRL_RUN_BIT];
                    sel_q <= wd[CTRL_SEL_LSB +: SEL_W];
                end
                REG_RATE:   rate_q     <= wd[RATE_W-1:0];
                REG_TICK:   tick_ns_q  <= wd[TICK_W-1:0];
                REG_DIV:    div_q      <= wd[DIV_W-1:0];
                REG_TOD_HI: hi_stage_q <= wd[HI_W-1:0];
                REG_PER_0:  per_q[0]   <= wd[PER_W-1:0];
                REG_PER_1:  per_q[1]   <= wd[PER_W-1:0];
                default: ;
            endcase
        end
    end

    // Register reads; a low-time read captures the matching high half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q        <= '0;
            hi_shadow_q <= '0;
        end else if (rd_en) begin
            case (bus_word)
                REG_CTRL:   rd_q <= WORD_W'({sel_q, {(CTRL_SEL_LSB-1){1'b0}}, run_q});
                REG_RATE:   rd_q <= WORD_W'(rate_q);
                REG_TICK:   rd_q <= WORD_W'(tick_ns_q);
                REG_DIV:    rd_q <= WORD_W'(div_q);
                REG_TOD_LO: begin
                    rd_q        <= tod_ns[WORD_W-1:0];
                    hi_shadow_q <= tod_ns[TOD_W-1:WORD_W];
                end
                REG_TOD_HI: rd_q <= WORD_W'(hi_shadow_q);
                REG_PER_0:  rd_q <= WORD_W'(per_q[0]);
                default:    rd_q <= WORD_W'(per_q[1]);
            endcase
        end
    end

    ptp_rate_accum #(.ACC_W(RATE_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_q),
        .ref_hit_i (ref_hit),
        .rate_i    (rate_q),
        .tick_o    (tick)
    );

    ptp_tod_counter #(.TOD_W(TOD_W), .STEP_W(TICK_W)) u_tod (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_q),
        .tick_i     (tick),
        .step_i     (tick_ns_q),
        .load_i     (tod_load),
        .load_val_i ({hi_stage_q, wd}),
        .tod_o      (tod_ns)
    );

    ptp_out_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_q),
        .tick_i (tick),
        .div_i  (div_eff),
        .out_o  (out_clk)
    );

    generate
        for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
            ptp_interval_pulse #(.PER_W(PER_W), .STEP_W(TICK_W), .WID_W(DIV_W)) u_pg (
                .clk      (clk),
                .rst_n    (rst_n),
                .run_i    (run_q),
                .tick_i   (tick),
                .step_i   (tick_ns_q),
                .period_i (per_q[g]),
                .width_i  (div_eff),
                .pulse_o  (ivl_pulse[g])
            );
        end
    endgenerate

    AST_LOAD_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && wr_en && bus_word == REG_TOD_LO) |=> (tod_ns == '0)); // R4
endmodule

// File: tb/ptp_rate_timer_tb.sv
`timescale 1ns/1ps
module ptp_rate_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ref_stb = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] tod_ns;
    logic        out_clk;
    logic [1:0]  ivl_pulse;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ptp_rate_timer u_dut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb),
        .bus_en(bus_en), .bus_we(bus_we), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tod_ns(tod_ns), .out_clk(out_clk), .ivl_pulse(ivl_pulse)
    );

    // Rising-edge counters for the outputs, cleared on request.
    logic cnt_clr = 1'b0;
    int   rise_out, rise_p0, rise_p1;
    logic prev_out, prev_p0, prev_p1;
    always @(negedge clk) begin
        if (cnt_clr) begin
            rise_out = 0; rise_p0 = 0; rise_p1 = 0;
        end else begin
            if (out_clk && !prev_out)      rise_out++;
            if (ivl_pulse[0] && !prev_p0)  rise_p0++;
            if (ivl_pulse[1] && !prev_p1)  rise_p1++;
        end
        prev_out = out_clk; prev_p0 = ivl_pulse[0]; prev_p1 = ivl_pulse[1];
    end

    function automatic logic [31:0] flip(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_word = idx; bus_wdata = flip(v);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_word = idx;
        @(negedge clk);
        bus_en = 1'b0;
        v = flip(bus_rdata);
    endtask

    task automatic strobe(input int bitn, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_stb = 4'b0001 << bitn;
        end
        @(negedge clk);
        ref_stb = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_counts();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] rate;
        logic [7:0]  tick;
        logic [15:0] n;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd0, 32'h8000_0000, 8'd10,  16'd20, 64'd100},
        '{2'd1, 32'h9999_99A4, 8'd10,  16'd10, 64'd60},
        '{2'd2, 32'hFFFF_FFFF, 8'd8,   16'd5,  64'd32},
        '{2'd3, 32'h4000_0000, 8'd255, 16'd13, 64'd765},
        '{2'd1, 32'h0000_0000, 8'd10,  16'd7,  64'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 tod", tod_ns, 64'd0);
        chk("R1 out_clk", {63'd0, out_clk}, 64'd0);
        chk("R1 pulses", {62'd0, ivl_pulse}, 64'd0);
        rd(3'd0, v);
        chk("R1 ctrl", {32'd0, v}, 64'd0);

        // R2: vector table over rates, periods and sources
        foreach (VECS[k]) begin
            wr(3'd0, {26'd0, VECS[k].sel, 4'd0});
            wr(3'd1, VECS[k].rate);
            wr(3'd2, {24'd0, VECS[k].tick});
            wr(3'd0, {26'd0, VECS[k].sel, 4'd1});
            strobe(int'(VECS[k].sel), int'(VECS[k].n));
            chk($sformatf("R2 vector %0d", k), tod_ns, VECS[k].exp);
        end

        // R10: raw bus word of CTRL (run=1, sel=1 -> 0x11) is byte reversed
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_word = 3'd0;
        @(negedge clk);
        bus_en = 1'b0;
        chk("R10 raw ctrl", {32'd0, bus_rdata}, 64'h1100_0000);

        // R3: unselected source ignored, selected source counted
        wr(3'd0, 32'h10);
        wr(3'd1, 32'h8000_0000);
        wr(3'd2, 32'd10);
        wr(3'd0, 32'h11);
        strobe(2, 10);
        chk("R3 other source", tod_ns, 64'd0);
        strobe(1, 2);
        chk("R3 selected source", tod_ns, 64'd10);

        // R4: halted block ignores strobes and time writes
        wr(3'd0, 32'h00);
        strobe(0, 10);
        chk("R4 halted strobes", tod_ns, 64'd0);
        wr(3'd5, 32'd0);
        wr(3'd4, 32'h1234);
        wr(3'd0, 32'h01);
        rd(3'd4, v);
        chk("R4 halted write", {32'd0, v}, 64'd0);

        // R5: rate change keeps phase and time
        strobe(0, 4);
        chk("R5 before change", tod_ns, 64'd20);
        wr(3'd1, 32'hC000_0000);
        strobe(0, 3);
        chk("R5 after change", tod_ns, 64'd40);

        // R6: 64-bit load and coherent split read
        wr(3'd5, 32'd1);
        wr(3'd4, 32'hFFFF_FFF0);
        chk("R6 load", tod_ns, 64'h1_FFFF_FFF0);
        rd(3'd4, v);
        chk("R6 low read", {32'd0, v}, 64'hFFFF_FFF0);
        wr(3'd1, 32'h8000_0000);
        strobe(0, 4);
        chk("R6 advanced", tod_ns, 64'h2_0000_0004);
        rd(3'd5, v);
        chk("R6 high captured", {32'd0, v}, 64'd1);
        rd(3'd4, v);
        rd(3'd5, v);
        chk("R6 high fresh", {32'd0, v}, 64'd2);

        // R7 R8 R9: divider 4, periods 40 ns (5 ticks) and 90 ns (10 ticks)
        wr(3'd0, 32'h00);
        wr(3'd3, 32'd4);
        wr(3'd6, 32'd40);
        wr(3'd7, 32'd90);
        wr(3'd0, 32'h01);
        clear_counts();
        strobe(0, 60);
        chk("R7 out_clk rises div4", 64'(rise_out), 64'd8);
        chk("R8 pulse0 rises", 64'(rise_p0), 64'd6);
        chk("R8 pulse1 rises", 64'(rise_p1), 64'd3);
        chk("R9 pulse0 high after expiry", {63'd0, ivl_pulse[0]}, 64'd1);
        strobe(0, 6);
        chk("R9 pulse0 high through width", {63'd0, ivl_pulse[0]}, 64'd1);
        strobe(0, 2);
        chk("R9 pulse0 low after width", {63'd0, ivl_pulse[0]}, 64'd0);

        // R7: divide value 1 acts as 2
        wr(3'd0, 32'h00);
        wr(3'd3, 32'd1);
        wr(3'd0, 32'h01);
        clear_counts();
        strobe(0, 20);
        chk("R7 out_clk rises div1", 64'(rise_out), 64'd5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule